// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit sits between the event sources of a 16550-class serial controller and its host bus. It holds a four-bit interrupt enable register, tracks modem-line changes as sticky delta flags, and reduces all pending enabled sources to one prioritised identification byte and one interrupt request line. The receiver, FIFO and transmitter report their conditions as levels. A bus decoder, which is outside this unit, turns register reads and writes into single-cycle strobes.

Software reads the identification byte to learn the highest-priority cause. It then services that cause. Reading the identification byte while it reports a transmit-holding-empty cause acknowledges that cause. Reading the modem-status byte acknowledges all modem-line changes. Every output is a flop and follows its inputs one clock later.

Top module: `uart_irq_ident`

## Requirements
- R1: Reset clears the enable register to 0. A write strobe loads the 4-bit write data, which reads back on the next cycle. The enable bits are: bit0 received data or timeout, bit1 transmit holding empty, bit2 receiver line status, bit3 modem status.
- R2: Identification bit0 is 0 while any enabled source is pending and 1 otherwise. With nothing pending, bits 3:0 read 0x1, which is not a valid cause code.
- R3: Identification bits 3:0 carry the cause code: 0x6 for line error, 0x4 for received data available, 0xC for character timeout, 0x2 for transmit holding empty, and 0x0 for modem status.
- R4: When several enabled sources are pending, the one reported is chosen in this order: line error, then received data, then character timeout, then transmit empty, then modem status.
- R5: Identification bits 7:6 both read 1 when the FIFO-enable input is high and both read 0 otherwise. Bits 5:4 always read 0.
- R6: An identification read strobe issued while bits 3:0 read 0x2 disarms the transmit-empty source. An identification read issued while any other code is shown leaves that source armed.
- R7: The transmit-empty source re-arms on a holding-register write strobe, or on an enable write that takes bit1 from 0 to 1. A write that leaves bit1 at 1 does not re-arm it.
- R8: The modem-status byte holds the live CTS, DSR, RI and DCD levels in bits 4, 5, 6 and 7. Any change of CTS, DSR or DCD sets its delta flag: bit0, bit1 or bit3 respectively.
- R9: The ring delta (bit2) sets only on a 1-to-0 transition of RI. A 0-to-1 transition has no effect on it.
- R10: A modem-status read strobe clears the four delta bits. A line change in the same cycle as the read still sets its delta flag.
- R11: The interrupt output is high exactly when an enabled source is pending. A disabled source never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 4 | Enable register write data |
| thr_wr_i | input | 1 | Holding register write strobe |
| iir_rd_i | input | 1 | Identification read strobe |
| msr_rd_i | input | 1 | Modem-status read strobe |
| line_err_i | input | 1 | Receiver line error level |
| rx_avail_i | input | 1 | Received data available level |
| rx_timeout_i | input | 1 | Character timeout level |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| fifo_en_i | input | 1 | FIFOs enabled level |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| ri_i | input | 1 | Ring indicator line |
| dcd_i | input | 1 | Carrier detect line |
| ier_o | output | 4 | Enable register contents |
| iir_o | output | 8 | Identification byte |
| msr_o | output | 8 | Modem-status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Most internal faults in this unit show up at the ports within two clocks. A wrong transmit-empty arm flag makes code 0x2 appear after an acknowledge, or fail to return after a holding write. A stuck or misrouted delta flag changes the low nibble of the modem-status byte, and also changes the 0x0 cause when the modem enable bit is set. A priority or encoding fault corrupts the identification byte, so the bench compares every enable value with every combination of source levels against an arithmetic model. That comparison covers the ordering and the disabled-source cases.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int EN_W    = 4;
  localparam int CODE_W  = 4;
  localparam int ID_W    = 8;
  localparam int LINES_N = 4;
  localparam int RING_IDX = 2;

  localparam logic [CODE_W-1:0] CODE_LINE  = 4'h6;
  localparam logic [CODE_W-1:0] CODE_RXDAT = 4'h4;
  localparam logic [CODE_W-1:0] CODE_TMO   = 4'hC;
  localparam logic [CODE_W-1:0] CODE_THRE  = 4'h2;
  localparam logic [CODE_W-1:0] CODE_MODEM = 4'h0;
  localparam logic [CODE_W-1:0] CODE_IDLE  = 4'h1;

  typedef enum logic [1:0] {EN_RX = 2'd0, EN_TX = 2'd1, EN_LINE = 2'd2, EN_MS = 2'd3} en_bit_e;
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
#(
  parameter int W = EN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         thr_wr,
  input  logic         thre_ack,
  output logic [W-1:0] en_q,
  output logic         thre_armed
);
  logic tx_rise;
  assign tx_rise = wr && wdata[EN_TX] && !en_q[EN_TX];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      thre_armed <= 1'b0;
    end else begin
      if (wr) en_q <= wdata;
      if (thr_wr || tx_rise) thre_armed <= 1'b1;
      else if (thre_ack)     thre_armed <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
  import uart_irq_pkg::*;
#(
  parameter int N = LINES_N,
  parameter int RI_POS = RING_IDX
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  input  logic         clr,
  output logic [N-1:0] live_q,
  output logic [N-1:0] delta_q
);
  logic primed;
  logic [N-1:0] evt;

  for (genvar i = 0; i < N; i++) begin : g_evt
    if (i == RI_POS) begin : g_trail
      assign evt[i] = primed && live_q[i] && !lines[i];
    end else begin : g_any
      assign evt[i] = primed && (live_q[i] != lines[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      live_q  <= '0;
      delta_q <= '0;
    end else begin
      primed  <= 1'b1;
      live_q  <= lines;
      delta_q <= (clr ? '0 : delta_q) | evt;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int W = EN_W,
  parameter int IW = ID_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  en,
  input  logic          line_err,
  input  logic          rx_avail,
  input  logic          rx_tmo,
  input  logic          thre_pend,
  input  logic          ms_pend,
  input  logic          fifo_en,
  output logic [IW-1:0] id_q,
  output logic          irq_q
);
  localparam int PAD_W = IW - CODE_W - 2;
  logic [CODE_W-1:0] code;
  logic              any;

  always_comb begin
    any = 1'b1;
    if (en[EN_LINE] && line_err)     code = CODE_LINE;
    else if (en[EN_RX] && rx_avail)  code = CODE_RXDAT;
    else if (en[EN_RX] && rx_tmo)    code = CODE_TMO;
    else if (en[EN_TX] && thre_pend) code = CODE_THRE;
    else if (en[EN_MS] && ms_pend)   code = CODE_MODEM;
    else begin
      code = CODE_IDLE;
      any  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_q  <= {{(IW-CODE_W){1'b0}}, CODE_IDLE};
      irq_q <= 1'b0;
    end else begin
      id_q  <= {{2{fifo_en}}, {PAD_W{1'b0}}, code};
      irq_q <= any;
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ier_wr_i,
  input  logic [EN_W-1:0] ier_wdata_i,
  input  logic            thr_wr_i,
  input  logic            iir_rd_i,
  input  logic            msr_rd_i,
  input  logic            line_err_i,
  input  logic            rx_avail_i,
  input  logic            rx_timeout_i,
  input  logic            thr_empty_i,
  input  logic            fifo_en_i,
  input  logic            cts_i,
  input  logic            dsr_i,
  input  logic            ri_i,
  input  logic            dcd_i,
  output logic [EN_W-1:0] ier_o,
  output logic [ID_W-1:0] iir_o,
  output logic [7:0]      msr_o,
  output logic            irq_o
);
  logic thre_armed;
  logic thre_ack;
  logic [LINES_N-1:0] live, delta;

  assign thre_ack = iir_rd_i && (iir_o[CODE_W-1:0] == CODE_THRE);

  uart_irq_enable #(.W(EN_W)) u_en (
    .clk(clk), .rst(rst), .wr(ier_wr_i), .wdata(ier_wdata_i),
    .thr_wr(thr_wr_i), .thre_ack(thre_ack),
    .en_q(ier_o), .thre_armed(thre_armed)
  );

  uart_irq_modem #(.N(LINES_N), .RI_POS(RING_IDX)) u_ms (
    .clk(clk), .rst(rst), .lines({dcd_i, ri_i, dsr_i, cts_i}),
    .clr(msr_rd_i), .live_q(live), .delta_q(delta)
  );

  uart_irq_prio #(.W(EN_W), .IW(ID_W)) u_pr (
    .clk(clk), .rst(rst), .en(ier_o),
    .line_err(line_err_i), .rx_avail(rx_avail_i), .rx_tmo(rx_timeout_i),
    .thre_pend(thr_empty_i && thre_armed), .ms_pend(|delta),
    .fifo_en(fifo_en_i), .id_q(iir_o), .irq_q(irq_o)
  );

  assign msr_o = {live, delta};
endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker (
  input logic       clk,
  input logic       rst,
  input logic       ier_wr_i,
  input logic [3:0] ier_wdata_i,
  input logic       msr_rd_i,
  input logic       fifo_en_i,
  input logic       cts_i,
  input logic       dsr_i,
  input logic       ri_i,
  input logic       dcd_i,
  input logic [3:0] ier_o,
  input logic [7:0] iir_o,
  input logic [7:0] msr_o,
  input logic       irq_o
);
  assert_ier_load_R1: assert property (@(posedge clk) disable iff (rst)
    ier_wr_i |=> ier_o == $past(ier_wdata_i));

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (rst)
    iir_o[0] |-> iir_o[3:0] == 4'h1);

  assert_valid_cause_R3: assert property (@(posedge clk) disable iff (rst)
    !iir_o[0] |-> (iir_o[3:0] inside {4'h6, 4'h4, 4'hC, 4'h2, 4'h0}));

  assert_fifo_bits_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> iir_o[7:6] == {2{$past(fifo_en_i)}} && iir_o[5:4] == 2'b00);

  assert_msr_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (msr_rd_i && {dcd_i, ri_i, dsr_i, cts_i} == msr_o[7:4]) |=> msr_o[3:0] == 4'h0);

  assert_irq_pending_R11: assert property (@(posedge clk) disable iff (rst)
    irq_o == !iir_o[0]);
endmodule

bind uart_irq_ident uart_irq_checker u_chk (
  .clk(clk), .rst(rst), .ier_wr_i(ier_wr_i), .ier_wdata_i(ier_wdata_i),
  .msr_rd_i(msr_rd_i), .fifo_en_i(fifo_en_i), .cts_i(cts_i), .dsr_i(dsr_i),
  .ri_i(ri_i), .dcd_i(dcd_i), .ier_o(ier_o), .iir_o(iir_o), .msr_o(msr_o),
  .irq_o(irq_o)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  logic clk = 0;
  logic rst = 1;
  logic ier_wr = 0, thr_wr = 0, iir_rd = 0, msr_rd = 0;
  logic [3:0] ier_wdata = 0;
  logic line_err = 0, rx_avail = 0, rx_tmo = 0, thr_empty = 0, fifo_en = 0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic [3:0] ier_o;
  logic [7:0] iir_o, msr_o;
  logic irq_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst(rst), .ier_wr_i(ier_wr), .ier_wdata_i(ier_wdata),
    .thr_wr_i(thr_wr), .iir_rd_i(iir_rd), .msr_rd_i(msr_rd),
    .line_err_i(line_err), .rx_avail_i(rx_avail), .rx_timeout_i(rx_tmo),
    .thr_empty_i(thr_empty), .fifo_en_i(fifo_en), .cts_i(cts), .dsr_i(dsr),
    .ri_i(ri), .dcd_i(dcd), .ier_o(ier_o), .iir_o(iir_o), .msr_o(msr_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ier(input logic [3:0] v);
    ier_wdata = v; ier_wr = 1; cyc(1); ier_wr = 0;
  endtask

  task automatic pulse_thr();  thr_wr = 1; cyc(1); thr_wr = 0; endtask
  task automatic pulse_iir();  iir_rd = 1; cyc(1); iir_rd = 0; endtask
  task automatic pulse_msr();  msr_rd = 1; cyc(1); msr_rd = 0; endtask

  function automatic logic [7:0] model(input logic [3:0] en, input logic le,
      input logic av, input logic tm, input logic te, input logic ms, input logic fe);
    logic [3:0] c;
    if (en[2] && le) c = 4'h6;
    else if (en[0] && av) c = 4'h4;
    else if (en[0] && tm) c = 4'hC;
    else if (en[1] && te) c = 4'h2;
    else if (en[3] && ms) c = 4'h0;
    else c = 4'h1;
    return {{2{fe}}, 2'b00, c};
  endfunction

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(2);
    // R1 R2 reset state
    chk("R1 reset enable", {4'h0, ier_o}, 8'h00);
    chk("R2 reset idle", iir_o, 8'h01);
    chk("R11 reset irq", {7'h0, irq_o}, 8'h00);
    chk("R8 reset msr", msr_o, 8'h00);

    // R1 load and readback
    pulse_ier(4'hA); cyc(1);
    chk("R1 enable readback", {4'h0, ier_o}, 8'h0A);

    // Arm THRE and create a pending CTS delta for the sweep
    pulse_thr();
    cts = 1; cyc(2);

    // R3 R4 R5 R11 sweep over all enables and source levels
    for (int e = 0; e < 16; e++) begin
      pulse_ier(e[3:0]);
      for (int s = 0; s < 16; s++) begin
        line_err = s[0]; rx_avail = s[1]; rx_tmo = s[2]; thr_empty = s[3];
        fifo_en = e[0] ^ s[0];
        cyc(2);
        chk("R3 R4 R5 sweep iir", iir_o,
            model(e[3:0], s[0], s[1], s[2], s[3], 1'b1, e[0] ^ s[0]));
        chk("R11 sweep irq", {7'h0, irq_o},
            {7'h0, model(e[3:0], s[0], s[1], s[2], s[3], 1'b1, 1'b0)[0] == 1'b0});
      end
    end
    line_err = 0; rx_avail = 0; rx_tmo = 0; thr_empty = 0; fifo_en = 0;

    // R6: read while another code shown leaves THRE armed
    pulse_ier(4'h3); thr_empty = 1; rx_avail = 1; cyc(2);
    chk("R3 rx over thre", iir_o, 8'h04);
    pulse_iir(); rx_avail = 0; cyc(2);
    chk("R6 other read keeps thre", iir_o, 8'h02);
    // R6: read while THRE shown disarms
    pulse_iir(); cyc(2);
    chk("R6 thre acknowledged", iir_o, 8'h01);
    chk("R11 no irq after ack", {7'h0, irq_o}, 8'h00);
    // R7 holding write re-arms
    pulse_thr(); cyc(2);
    chk("R7 thr write rearms", iir_o, 8'h02);
    pulse_iir(); cyc(2);
    // R7 enable rewrite without rise does not re-arm
    pulse_ier(4'h3); cyc(2);
    chk("R7 no rise no rearm", iir_o, 8'h01);
    pulse_ier(4'h1); pulse_ier(4'h2); cyc(2);
    chk("R7 enable rise rearms", iir_o, 8'h02);
    thr_empty = 0;

    // Modem-status behaviour
    pulse_ier(4'h8); cyc(2);
    chk("R3 modem cause", iir_o, 8'h00);
    chk("R11 modem irq", {7'h0, irq_o}, 8'h01);
    pulse_msr(); cyc(2);
    chk("R10 read clears deltas", msr_o, 8'h10);
    chk("R10 cause gone after read", iir_o, 8'h01);
    dsr = 1; cyc(2);
    chk("R8 dsr delta", msr_o, 8'h32);
    pulse_msr(); cyc(1);
    ri = 1; cyc(2);
    chk("R9 ri rise ignored", msr_o, 8'h70);
    chk("R9 ri rise no cause", iir_o, 8'h01);
    ri = 0; cyc(2);
    chk("R9 ri fall sets", msr_o, 8'h34);
    pulse_msr(); cyc(1);
    dcd = 1; cyc(2);
    chk("R8 dcd delta", msr_o, 8'hB8);
    pulse_msr(); cyc(1);
    cts = 0; cyc(2);
    chk("R8 cts fall delta", msr_o, 8'hA1);
    pulse_msr(); cyc(1);
    chk("R10 cleared again", msr_o, 8'hA0);
    // R10 change coinciding with read still recorded
    msr_rd = 1; dsr = 0; cyc(1); msr_rd = 0; cyc(2);
    chk("R10 change during read kept", msr_o, 8'h82);

    // R11 disabled modem source raises nothing
    pulse_ier(4'h0); cyc(2);
    chk("R11 disabled source", {7'h0, irq_o}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule